// File: doc/BRIEF.md
# RAM Sector Power Sequencer

This block decides, for each of up to four RAM sectors, what happens to that sector when the system drops into a deep low-power mode. A sector either keeps its contents in a retention state or is switched fully off. The choice sits in a control register that holds one bit per sector. That register is guarded: only a full 16-bit write that carries the right key in its upper byte can change it. A partial-width write, or a word write with any other key, leaves it untouched.

The block watches a two-bit low-power request and a wake pulse. On entry to a deep mode it copies the control bits and then steps the sectors down one at a time, lowest index first, which limits the current surge. A wake event brings the sectors back up in the same order. For each sector it reports:

- the current power state;
- an access-block flag;
- a sticky flag that marks the sector's contents as lost after it returns from the off state.

An access attempt aimed at a blocked sector raises a sticky error flag. Software clears the lost flags and the error flag with keyed write-one-to-clear writes to a status register.

Top module: `ram_sector_pwr_ctl`

## Requirements
- R1: After reset, every control bit is 0, every sector reports active (code 2'b00), no access-block output is high, and the lost flags and the error flag are 0.
- R2: A bus write with `bus_be` = 2'b11, `bus_addr` = 0 and `bus_wdata[15:8]` = 8'hA5 loads `bus_wdata[N-1:0]` into the control bits. A read always returns 8'h96 in bits [15:8]. A read at address 0 returns the control bits in the low bits, with all other bits zero.
- R3: A write with `bus_be` other than 2'b11, or with an upper byte other than 8'hA5, changes neither the control bits nor the status flags.
- R4: While running, a request of 2'b10 or 2'b11 on `lpm_req` is sampled at a rising edge. Sector i then changes state at the (i+1)-th following edge: to retention (2'b01) if its control bit was 0, or to off (2'b10) if it was 1. Requests 2'b00 and 2'b01 cause no change.
- R5: The control bits are copied at the edge that samples the deep request. Writes made after that edge apply only to the next entry.
- R6: In sleep, a wake pulse sampled at an edge returns sector i to active at the (i+1)-th following edge. A wake pulse outside the sleep state is ignored.
- R7: A sector that returns from off sets its lost flag, read at address 1 in bit i, and also driven on `sect_lost[i]`. The flag stays set until a keyed word write to address 1 has bit i set. If the set and the clear fall in the same cycle, the set wins.
- R8: `sect_blk[i]` is high exactly while sector i is not active.
- R9: An access strobe on `sect_acc[i]` while `sect_blk[i]` is high sets `acc_err` at the next edge. `acc_err` is read at address 1 in bit 7 and is cleared by a keyed word write to address 1 with bit 7 set. If the set and the clear fall in the same cycle, the set wins. Access to an active sector has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_be | input | 2 | Byte enables; 2'b11 marks a word write |
| bus_wdata | input | 16 | Write data, key in [15:8] |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| lpm_req | input | 2 | Low-power request; 2'b10 and 2'b11 are deep |
| wake | input | 1 | Wake event pulse |
| sect_acc | input | N_SECT | Per-sector access attempt strobe |
| sect_state | output | 2*N_SECT | Per-sector state, 2 bits each: 00 active, 01 retention, 10 off |
| sect_blk | output | N_SECT | Per-sector access-block flag |
| sect_lost | output | N_SECT | Per-sector sticky content-lost flag |
| acc_err | output | 1 | Sticky blocked-access error |

## Verification
Two status functions can fall on the same edge. A sector coming back from off sets its lost flag, while a software write-one-to-clear of that same flag arrives. Likewise, an access to a blocked sector can meet a clear of the error flag. The bench forces both collisions on purpose. It places a keyed status clear on the exact edge of a wake step whose sector was off, and it drives an access strobe together with an error clear while the system sleeps. It then judges the read-back against a model in which the set wins and the other flags are cleared.

// File: rtl/ramsp_pkg.sv
// Shared types for the RAM sector power sequencer.
// Assumes: state codes are visible at the top ports and must not be renumbered.
package ramsp_pkg;

    typedef enum logic [1:0] {
        PWR_ACT = 2'b00,
        PWR_RET = 2'b01,
        PWR_OFF = 2'b10
    } pwr_e;

    typedef enum logic [1:0] {
        PH_RUN   = 2'b00,
        PH_DOWN  = 2'b01,
        PH_SLEEP = 2'b10,
        PH_UP    = 2'b11
    } phase_e;

endpackage

// File: rtl/ramsp_regs.sv
// Keyed register file: control bits (address 0) and the status flags
// (address 1: lost bits in [N-1:0], error in bit 7).
// Assumes: N_SECT <= 4 so that bit 7 never overlaps a lost bit.
module ramsp_regs #(
    parameter int         N_SECT   = 4,
    parameter logic [7:0] WR_KEY   = 8'hA5,
    parameter logic [7:0] RD_KEY   = 8'h96,
    parameter int         ERR_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [15:0]       bus_wdata,
    input  logic [N_SECT-1:0] lost_evt,
    input  logic [N_SECT-1:0] err_evt,
    output logic [N_SECT-1:0] off_bits,
    output logic [N_SECT-1:0] lost,
    output logic              acc_err,
    output logic [15:0]       bus_rdata
);

    logic              keyed;
    logic [N_SECT-1:0] lost_clr;
    logic              err_clr;

    // Qualify a write: full word and matching key.
    always_comb begin
        keyed    = bus_wr && (bus_be == 2'b11) && (bus_wdata[15:8] == WR_KEY);
        lost_clr = (keyed && bus_addr) ? bus_wdata[N_SECT-1:0] : '0;
        err_clr  = keyed && bus_addr && bus_wdata[ERR_BIT];
    end

    // Control bits: load on a keyed write to address 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            off_bits <= '0;
        else if (keyed && !bus_addr)
            off_bits <= bus_wdata[N_SECT-1:0];
    end

    // Sticky status: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost    <= '0;
            acc_err <= 1'b0;
        end else begin
            lost    <= (lost & ~lost_clr) | lost_evt;
            acc_err <= (|err_evt) | (acc_err & ~err_clr);
        end
    end

    // Read mux with a fixed read-back key that cannot unlock a write.
    always_comb begin
        bus_rdata        = '0;
        bus_rdata[15:8]  = RD_KEY;
        if (!bus_addr) begin
            bus_rdata[N_SECT-1:0] = off_bits;
        end else begin
            bus_rdata[N_SECT-1:0] = lost;
            bus_rdata[ERR_BIT]    = acc_err;
        end
    end

    AST_BYTE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be != 2'b11) |=> $stable(off_bits)); // R3
    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[15:8] != WR_KEY) |=> $stable(off_bits)); // R3
    AST_KEYED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be == 2'b11 && bus_wdata[15:8] == WR_KEY && !bus_addr)
        |=> off_bits == $past(bus_wdata[N_SECT-1:0])); // R2
    AST_LOST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|lost_evt) |=> ((lost & $past(lost_evt)) == $past(lost_evt))); // R7
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_evt) |=> acc_err); // R9

endmodule

// File: rtl/ramsp_seq.sv
// Entry/exit sequencer: samples the deep request, freezes the control bits
// and issues one step strobe per cycle in ascending sector order.
// Assumes: wake and deep requests are acted on only in the sleep and run phases.
module ramsp_seq #(
    parameter int N_SECT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lpm_req,
    input  logic              wake,
    input  logic [N_SECT-1:0] off_bits,
    output logic [N_SECT-1:0] snap,
    output logic [N_SECT-1:0] dn_go,
    output logic [N_SECT-1:0] up_go
);
    import ramsp_pkg::*;

    localparam int            CW   = (N_SECT > 1) ? $clog2(N_SECT) : 1;
    localparam logic [CW-1:0] LAST = CW'(N_SECT - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    // Phase and step counter progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_RUN;
            cnt   <= '0;
            snap  <= '0;
        end else begin
            case (phase)
                PH_RUN: if (lpm_req[1]) begin
                    snap  <= off_bits;
                    phase <= PH_DOWN;
                    cnt   <= '0;
                end
                PH_DOWN: if (cnt == LAST) begin
                    phase <= PH_SLEEP;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                PH_SLEEP: if (wake) begin
                    phase <= PH_UP;
                    cnt   <= '0;
                end
                default: if (cnt == LAST) begin
                    phase <= PH_RUN;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Decode one step strobe per sector.
    for (genvar i = 0; i < N_SECT; i++) begin : g_step
        assign dn_go[i] = (phase == PH_DOWN) && (cnt == CW'(i));
        assign up_go[i] = (phase == PH_UP)   && (cnt == CW'(i));
    end

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_RUN) |=> $stable(snap)); // R5
    AST_WAKE_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && !lpm_req[1]) |=> (phase == PH_RUN)); // R6
    AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SLEEP && !wake) |=> (phase == PH_SLEEP)); // R6

endmodule

// File: rtl/ramsp_sector.sv
// Per-sector power state holder: moves to retention or off on its down
// strobe, back to active on its up strobe, and flags events for status.
// Assumes: dn_go and up_go are never high together.
module ramsp_sector (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dn_go,
    input  logic       up_go,
    input  logic       off_sel,
    input  logic       acc,
    output logic [1:0] state,
    output logic       blk,
    output logic       lost_evt,
    output logic       err_evt
);
    import ramsp_pkg::*;

    pwr_e st;

    // Sector state register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= PWR_ACT;
        else if (dn_go)
            st <= off_sel ? PWR_OFF : PWR_RET;
        else if (up_go)
            st <= PWR_ACT;
    end

    // Outputs and events derived from the held state.
    always_comb begin
        state    = st;
        blk      = (st != PWR_ACT);
        lost_evt = up_go && (st == PWR_OFF);
        err_evt  = acc && (st != PWR_ACT);
    end

    AST_RET_WHEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_go && !off_sel) |=> (state == 2'b01)); // R4
    AST_OFF_WHEN_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_go && off_sel) |=> (state == 2'b10)); // R4
    AST_WAKE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        up_go |=> (state == 2'b00 && !blk)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_go && !up_go) |=> $stable(state)); // R4

endmodule

// File: rtl/ram_sector_pwr_ctl.sv
// Top: keyed retention/off control for N_SECT RAM sectors with sequenced
// entry and exit of deep low-power modes.
// Assumes: 1 <= N_SECT <= 4; lpm_req 2'b10/2'b11 are the deep modes.
module ram_sector_pwr_ctl #(
    parameter int N_SECT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_addr,
    input  logic [1:0]            bus_be,
    input  logic [15:0]           bus_wdata,
    output logic [15:0]           bus_rdata,
    input  logic [1:0]            lpm_req,
    input  logic                  wake,
    input  logic [N_SECT-1:0]     sect_acc,
    output logic [2*N_SECT-1:0]   sect_state,
    output logic [N_SECT-1:0]     sect_blk,
    output logic [N_SECT-1:0]     sect_lost,
    output logic                  acc_err
);

    logic [N_SECT-1:0] off_bits;
    logic [N_SECT-1:0] snap;
    logic [N_SECT-1:0] dn_go;
    logic [N_SECT-1:0] up_go;
    logic [N_SECT-1:0] lost_evt;
    logic [N_SECT-1:0] err_evt;

    ramsp_regs #(.N_SECT(N_SECT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .lost_evt  (lost_evt),
        .err_evt   (err_evt),
        .off_bits  (off_bits),
        .lost      (sect_lost),
        .acc_err   (acc_err),
        .bus_rdata (bus_rdata)
    );

    ramsp_seq #(.N_SECT(N_SECT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpm_req  (lpm_req),
        .wake     (wake),
        .off_bits (off_bits),
        .snap     (snap),
        .dn_go    (dn_go),
        .up_go    (up_go)
    );

    for (genvar i = 0; i < N_SECT; i++) begin : g_sect
        ramsp_sector u_sect (
            .clk      (clk),
            .rst_n    (rst_n),
            .dn_go    (dn_go[i]),
            .up_go    (up_go[i]),
            .off_sel  (snap[i]),
            .acc      (sect_acc[i]),
            .state    (sect_state[2*i +: 2]),
            .blk      (sect_blk[i]),
            .lost_evt (lost_evt[i]),
            .err_evt  (err_evt[i])
        );
    end

    AST_ONE_STEP_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_go | up_go)); // R4

endmodule

// File: tb/ram_sector_pwr_ctl_tb.sv
module ram_sector_pwr_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  lpm_req = 2'b00;
    logic        wake = 1'b0;
    logic [NS-1:0]   sect_acc = '0;
    logic [2*NS-1:0] sect_state;
    logic [NS-1:0]   sect_blk;
    logic [NS-1:0]   sect_lost;
    logic            acc_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [NS-1:0]   m_ctrl = '0;
    logic [NS-1:0]   m_lost = '0;
    logic            m_err  = 1'b0;
    logic [1:0]      m_st [NS];

    ram_sector_pwr_ctl #(.N_SECT(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lpm_req(lpm_req), .wake(wake), .sect_acc(sect_acc),
        .sect_state(sect_state), .sect_blk(sect_blk), .sect_lost(sect_lost),
        .acc_err(acc_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2*NS-1:0] pack_st();
        logic [2*NS-1:0] v;
        for (int i = 0; i < NS; i++) v[2*i +: 2] = m_st[i];
        return v;
    endfunction

    function automatic logic [NS-1:0] exp_blk();
        logic [NS-1:0] v;
        for (int i = 0; i < NS; i++) v[i] = (m_st[i] != 2'b00);
        return v;
    endfunction

    function automatic bit is_keyed(input logic [1:0] be, input logic [15:0] d);
        return (be == 2'b11) && (d[15:8] == 8'hA5);
    endfunction

    function automatic logic [15:0] exp_rd(input logic a);
        logic [15:0] v = 16'h9600;
        if (!a) v[NS-1:0] = m_ctrl;
        else begin v[NS-1:0] = m_lost; v[7] = m_err; end
        return v;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req);
        chk({req, " state"}, 16'(sect_state), 16'(pack_st()));
        chk("R8 blk", 16'(sect_blk), 16'(exp_blk()));
        chk("R7 lost", 16'(sect_lost), 16'(m_lost));
        chk("R9 err", 16'(acc_err), 16'(m_err));
    endtask

    task automatic rd_chk(input logic a, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    // Called at a negedge; performs one write across the next edge.
    task automatic bus_write(input logic a, input logic [1:0] be, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (is_keyed(be, d)) begin
            if (!a) m_ctrl = d[NS-1:0];
            else begin
                m_lost = m_lost & ~d[NS-1:0];
                if (d[7]) m_err = 1'b0;
            end
        end
    endtask

    // One low-power episode; called at a negedge.
    task automatic episode(input logic [1:0] lvl, input bit mid_wr,
                           input logic [1:0] mid_be, input logic [15:0] mid_d,
                           input logic [NS-1:0] acc, input bit err_clr,
                           input int clr_step, input logic [15:0] clr_d);
        logic [NS-1:0] snap;
        lpm_req = lvl;
        snap = m_ctrl;
        @(negedge clk);
        lpm_req = 2'b00;
        chk_outs("R4 sample edge");
        if (!lvl[1]) begin
            for (int k = 0; k < NS + 1; k++) @(negedge clk);
            chk_outs("R4 shallow ignored");
            return;
        end
        if (mid_wr) begin
            bus_wr = 1'b1; bus_addr = 1'b0; bus_be = mid_be; bus_wdata = mid_d;
        end
        for (int i = 0; i < NS; i++) begin
            @(negedge clk);
            if (i == 0 && mid_wr) begin
                bus_wr = 1'b0;
                if (is_keyed(mid_be, mid_d)) m_ctrl = mid_d[NS-1:0];
            end
            m_st[i] = snap[i] ? 2'b10 : 2'b01;
            chk_outs("R4 down step");
        end
        rd_chk(1'b0, "R5 ctrl during sleep");
        // Access attempts while blocked, optionally with an error clear.
        sect_acc = acc;
        if (err_clr) begin
            bus_wr = 1'b1; bus_addr = 1'b1; bus_be = 2'b11; bus_wdata = 16'hA580;
        end
        @(negedge clk);
        sect_acc = '0;
        bus_wr = 1'b0;
        if (|acc) m_err = 1'b1;
        else if (err_clr) m_err = 1'b0;
        chk_outs("R9 blocked access");
        rd_chk(1'b1, "R9 status read");
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        chk_outs("R6 wake sample edge");
        for (int i = 0; i < NS; i++) begin
            if (i == clr_step) begin
                bus_wr = 1'b1; bus_addr = 1'b1; bus_be = 2'b11; bus_wdata = clr_d;
            end
            @(negedge clk);
            bus_wr = 1'b0;
            if (i == clr_step) begin
                m_lost = m_lost & ~clr_d[NS-1:0];
                if (clr_d[7]) m_err = 1'b0;
            end
            if (snap[i]) m_lost[i] = 1'b1;
            m_st[i] = 2'b00;
            chk_outs("R6 R7 up step");
        end
        rd_chk(1'b1, "R7 status after wake");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NS; i++) m_st[i] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_outs("R1 reset");
        rd_chk(1'b0, "R1 ctrl reset");
        rd_chk(1'b1, "R1 status reset");
        // R3 partial and wrong-key writes
        bus_write(1'b0, 2'b01, 16'hA50F); rd_chk(1'b0, "R3 low byte write");
        bus_write(1'b0, 2'b10, 16'hA50F); rd_chk(1'b0, "R3 high byte write");
        bus_write(1'b0, 2'b11, 16'h5A0F); rd_chk(1'b0, "R3 wrong key");
        bus_write(1'b0, 2'b11, 16'h960F); rd_chk(1'b0, "R3 read key rejected");
        // R2 keyed write
        bus_write(1'b0, 2'b11, 16'hA50F); rd_chk(1'b0, "R2 keyed write");
        bus_write(1'b0, 2'b11, 16'hA505); rd_chk(1'b0, "R2 keyed write 2");
        // R6 wake while running; R9 access to active sectors
        wake = 1'b1; sect_acc = 4'hF;
        @(negedge clk);
        wake = 1'b0; sect_acc = '0;
        repeat (2) @(negedge clk);
        chk_outs("R6 R9 wake and access while running");
        // R4 shallow request ignored
        episode(2'b01, 0, 2'b11, 16'h0, '0, 0, NS, 16'h0);
        // Directed: R5 mid write, R9 blocked access, R7 coincident set/clear at sector 2
        episode(2'b10, 1, 2'b11, 16'hA50A, 4'b0010, 0, 2, 16'hA58F);
        rd_chk(1'b0, "R5 mid write kept for next entry");
        // Directed: R9 set wins over clear in same cycle; next entry uses 4'hA (R5)
        episode(2'b11, 0, 2'b11, 16'h0, 4'b1000, 1, NS, 16'h0);
        // Random episodes and writes
        for (int n = 0; n < 40; n++) begin
            logic [1:0]  be  = 2'($urandom_range(0, 3));
            logic [15:0] d   = {(($urandom_range(0, 2) != 0) ? 8'hA5 : 8'($urandom)), 8'($urandom)};
            logic        a   = 1'($urandom_range(0, 1));
            bus_write(a, be, d);
            rd_chk(1'b0, "R2 R3 random write ctrl");
            rd_chk(1'b1, "R3 R7 random write status");
            episode(2'($urandom_range(0, 3)), 1'($urandom), 2'($urandom_range(2, 3)),
                    {(($urandom_range(0, 1) != 0) ? 8'hA5 : 8'h3C), 8'($urandom)},
                    NS'($urandom), 1'($urandom), $urandom_range(0, NS),
                    {8'hA5, 8'($urandom)});
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule